// File: doc/BRIEF.md
# Set-Partitioned Pin Routing Pool

This block is the global interconnect of a pin crosspoint. It takes the live levels of all bidirectional pins and, for each output cell, picks the signals the cell needs. Each cell gets four multiplexer data inputs, an output enable, a clock, a clock enable and two dynamic select lines. The pins are divided into four equal sets. Every routed signal may come only from its own designated set, so each selector covers a quarter of the pins rather than all of them. One pin may feed any number of cells at once.

The routing choices live in a configuration memory. The memory is loaded serially through a shadow shift register and committed to the active copy by a separate update strobe, so the routing never changes while bits are still moving. A cell's clock may come from one of several dedicated global clock inputs instead of a pin. Until the first commit after reset, every cell output, including its enable, is held low.

Top module: `gr_pool`

## Requirements
- R1: While `cfg_shift` is high, each clock edge moves the shadow register one place toward bit 0 and loads `cfg_sin` into its top bit. `cfg_sout` always shows bit 0, so the first bit shifted in after a full load of `NCELLS*21` bits appears on `cfg_sout`. While `cfg_shift` is low, the shadow register and `cfg_sout` hold their values.
- R2: A high `cfg_update` at a clock edge copies the shadow register, as it was before that edge, into the active configuration. Shifting without an update leaves every routed output unchanged. Cell c owns bits [c*21 +: 21] of the active configuration. From its low end upward, those bits hold: data select 0, data select 1, data select 2, data select 3, enable select, clock select, clock-enable select, select-0 select and select-1 select, each 2 bits wide; then a 1-bit global clock flag; then a 2-bit global clock index.
- R3: After reset, and until the first update, every cell's `cell_oe`, `cell_data`, `cell_clk`, `cell_clken` and `cell_msel` bit is 0, whatever the pins do.
- R4: Pin set k holds pins [4k +: 4]: set A is k=0, set B is k=1, set C is k=2 and set D is k=3. Data input d of cell c, `cell_data[c*4+d]`, equals `pin_in[4d + dsel_d]`. Data input d can therefore reach only set d.
- R5: `cell_oe[c]` equals `pin_in[0 + oe_sel]`, so the enable comes only from set A.
- R6: Clock and clock enable share set B. With the global flag clear, `cell_clk[c]` equals `pin_in[4 + clk_sel]`. `cell_clken[c]` always equals `pin_in[4 + clken_sel]`.
- R7: With the global flag set, `cell_clk[c]` equals `gclk_in[gidx]`.
- R8: `cell_msel[c*2]` equals `pin_in[8 + msel0_sel]`, from set C. `cell_msel[c*2+1]` equals `pin_in[12 + msel1_sel]`, from set D.
- R9: Several cells that select the same pin all follow that pin at the same time.
- R10: Reset clears the shadow register, so `cfg_sout` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift enable for the shadow register |
| cfg_sin | input | 1 | Serial configuration input |
| cfg_update | input | 1 | Commits the shadow register to the active configuration |
| cfg_sout | output | 1 | Serial output, bit 0 of the shadow register |
| pin_in | input | 16 | Pin levels seen by the pool |
| gclk_in | input | 4 | Dedicated global clock inputs |
| cell_data | output | NCELLS*4 | Routed multiplexer data inputs, four per cell |
| cell_oe | output | NCELLS | Routed output enable per cell |
| cell_clk | output | NCELLS | Routed clock per cell |
| cell_clken | output | NCELLS | Routed clock enable per cell |
| cell_msel | output | NCELLS*2 | Routed dynamic select pair per cell |

## Verification
The routing is driven with three kinds of pin pattern.
- A walking one over all sixteen pins shows that each selector reaches exactly one pin and only inside its own set. A wrong set offset or a wrong index lights the wrong output.
- All-ones and mixed patterns, such as alternating set values, catch inversions and swapped fields.
- A second configuration points every cell at the same pins and uses global clocks with distinct values per cell. This tells shared fan-out apart from per-cell wiring, and global clock routing apart from pin clock routing.

Shifting a new configuration in without an update, while the pins toggle, separates staging from commitment.

// File: rtl/gr_pkg.sv
package gr_pkg;
    localparam int NPINS   = 16;
    localparam int NSETS   = 4;
    localparam int SET_SZ  = NPINS / NSETS;
    localparam int SELW    = $clog2(SET_SZ);
    localparam int NGCLK   = 4;
    localparam int GW      = $clog2(NGCLK);
    localparam int NDATA   = 4;

    typedef enum logic [1:0] {SET_A, SET_B, SET_C, SET_D} pin_set_e;

    // lowest field first in bit order: dsel[0] occupies the low bits
    typedef struct packed {
        logic [GW-1:0]               gidx;
        logic                        glb;
        logic [SELW-1:0]             ms1;
        logic [SELW-1:0]             ms0;
        logic [SELW-1:0]             ce;
        logic [SELW-1:0]             ck;
        logic [SELW-1:0]             oe;
        logic [NDATA-1:0][SELW-1:0]  dsel;
    } cell_cfg_t;

    localparam int CELL_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic [NDATA-1:0] data;
        logic             oe;
        logic             clk;
        logic             clken;
        logic [1:0]       msel;
    } cell_route_t;

    function automatic int set_base(pin_set_e s);
        return int'(s) * SET_SZ;
    endfunction
endpackage

// File: rtl/gr_cfg_chain.sv
module gr_cfg_chain
    import gr_pkg::*;
#(
    parameter int TOT = 84
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           sin,
    input  logic           update,
    output logic [TOT-1:0] shadow_q,
    output logic [TOT-1:0] active_q,
    output logic           loaded_q,
    output logic           sout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            loaded_q <= 1'b0;
        end else begin
            if (shift_en) shadow_q <= {sin, shadow_q[TOT-1:1]};
            if (update) begin
                active_q <= shadow_q;
                loaded_q <= 1'b1;
            end
        end
    end

    assign sout = shadow_q[0];
endmodule

// File: rtl/gr_set_mux.sv
module gr_set_mux
    import gr_pkg::*;
#(
    parameter pin_set_e SET = SET_A
) (
    input  logic [NPINS-1:0] pins,
    input  logic [SELW-1:0]  sel,
    output logic             y
);
    localparam int BASE = set_base(SET);

    logic [SET_SZ-1:0] slice;
    assign slice = pins[BASE +: SET_SZ];

    always_comb begin
        y = 1'b0;
        for (int i = 0; i < SET_SZ; i++) begin
            if (sel == SELW'(i)) y = slice[i];
        end
    end
endmodule

// File: rtl/gr_cell_route.sv
module gr_cell_route
    import gr_pkg::*;
(
    input  cell_cfg_t         cfg,
    input  logic              loaded,
    input  logic [NPINS-1:0]  pins,
    input  logic [NGCLK-1:0]  gclk,
    output cell_route_t       route
);
    logic [NDATA-1:0] data_raw;
    logic oe_raw, ck_pin, ce_raw, ms0_raw, ms1_raw, ck_raw;

    for (genvar d = 0; d < NDATA; d++) begin : g_data
        gr_set_mux #(.SET(pin_set_e'(d))) u_dmux (
            .pins(pins), .sel(cfg.dsel[d]), .y(data_raw[d])
        );
    end

    gr_set_mux #(.SET(SET_A)) u_oe  (.pins(pins), .sel(cfg.oe),  .y(oe_raw));
    gr_set_mux #(.SET(SET_B)) u_ck  (.pins(pins), .sel(cfg.ck),  .y(ck_pin));
    gr_set_mux #(.SET(SET_B)) u_ce  (.pins(pins), .sel(cfg.ce),  .y(ce_raw));
    gr_set_mux #(.SET(SET_C)) u_ms0 (.pins(pins), .sel(cfg.ms0), .y(ms0_raw));
    gr_set_mux #(.SET(SET_D)) u_ms1 (.pins(pins), .sel(cfg.ms1), .y(ms1_raw));

    assign ck_raw = cfg.glb ? gclk[cfg.gidx] : ck_pin;

    always_comb begin
        route = '0;
        if (loaded) begin
            route.data  = data_raw;
            route.oe    = oe_raw;
            route.clk   = ck_raw;
            route.clken = ce_raw;
            route.msel  = {ms1_raw, ms0_raw};
        end
    end
endmodule

// File: rtl/gr_pool.sv
module gr_pool
    import gr_pkg::*;
#(
    parameter int NCELLS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_shift,
    input  logic                      cfg_sin,
    input  logic                      cfg_update,
    output logic                      cfg_sout,
    input  logic [NPINS-1:0]          pin_in,
    input  logic [NGCLK-1:0]          gclk_in,
    output logic [NCELLS*NDATA-1:0]   cell_data,
    output logic [NCELLS-1:0]         cell_oe,
    output logic [NCELLS-1:0]         cell_clk,
    output logic [NCELLS-1:0]         cell_clken,
    output logic [NCELLS*2-1:0]       cell_msel
);
    localparam int TOT = NCELLS * CELL_W;

    logic [TOT-1:0] shadow_q;
    logic [TOT-1:0] active_q;
    logic           loaded_q;

    gr_cfg_chain #(.TOT(TOT)) u_chain (
        .clk(clk), .rst(rst), .shift_en(cfg_shift), .sin(cfg_sin),
        .update(cfg_update), .shadow_q(shadow_q), .active_q(active_q),
        .loaded_q(loaded_q), .sout(cfg_sout)
    );

    for (genvar c = 0; c < NCELLS; c++) begin : g_cell
        cell_route_t r;
        gr_cell_route u_route (
            .cfg(cell_cfg_t'(active_q[c*CELL_W +: CELL_W])),
            .loaded(loaded_q), .pins(pin_in), .gclk(gclk_in), .route(r)
        );
        assign cell_data[c*NDATA +: NDATA] = r.data;
        assign cell_oe[c]                  = r.oe;
        assign cell_clk[c]                 = r.clk;
        assign cell_clken[c]               = r.clken;
        assign cell_msel[c*2 +: 2]         = r.msel;
    end
endmodule

// File: rtl/gr_pool_chk.sv
module gr_pool_chk #(
    parameter int NCELLS = 4,
    parameter int TOT    = 84
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_shift,
    input logic              cfg_update,
    input logic              cfg_sout,
    input logic [NCELLS-1:0] cell_oe,
    input logic [TOT-1:0]    shadow,
    input logic [TOT-1:0]    active,
    input logic              loaded
);
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |=> cfg_sout == $past(shadow[1])); // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_shift |=> $stable(shadow)); // R1
    AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (rst)
        cfg_update |=> active == $past(shadow)); // R2
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_update |=> $stable(active)); // R2
    AST_DARK_UNTIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> cell_oe == '0); // R3
    AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (rst)
        loaded |=> loaded); // R3
endmodule

bind gr_pool gr_pool_chk #(.NCELLS(NCELLS), .TOT(TOT)) u_chk (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_update(cfg_update),
    .cfg_sout(cfg_sout), .cell_oe(cell_oe), .shadow(shadow_q),
    .active(active_q), .loaded(loaded_q)
);

// File: tb/test_gr_pool.sv
module test_gr_pool;
    localparam int NC   = 4;
    localparam int CW   = 21;
    localparam int TOTB = NC * CW;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_shift = 1'b0, cfg_sin = 1'b0, cfg_update = 1'b0;
    logic cfg_sout;
    logic [15:0] pin_in = '0;
    logic [3:0]  gclk_in = '0;
    logic [NC*4-1:0] cell_data;
    logic [NC-1:0]   cell_oe, cell_clk, cell_clken;
    logic [NC*2-1:0] cell_msel;

    always #2 clk = ~clk;

    gr_pool #(.NCELLS(NC)) i_gr_pool (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_sin(cfg_sin),
        .cfg_update(cfg_update), .cfg_sout(cfg_sout), .pin_in(pin_in),
        .gclk_in(gclk_in), .cell_data(cell_data), .cell_oe(cell_oe),
        .cell_clk(cell_clk), .cell_clken(cell_clken), .cell_msel(cell_msel)
    );

    int checks = 0, errors = 0;

    // bench model of the routing configuration
    int m_dsel[NC][4];
    int m_oe[NC], m_ck[NC], m_ce[NC], m_ms0[NC], m_ms1[NC], m_glb[NC], m_gidx[NC];
    bit model_loaded = 0;
    logic [TOTB-1:0] staged;

    typedef struct {
        logic [NC*4-1:0] data;
        logic [NC-1:0]   oe, ck, ce;
        logic [NC*2-1:0] ms;
        string           req;
    } exp_t;
    exp_t sb[$];

    function automatic logic [TOTB-1:0] build_vec();
        logic [TOTB-1:0] v = '0;
        for (int c = 0; c < NC; c++) begin
            logic [CW-1:0] w;
            w = {2'(m_gidx[c]), 1'(m_glb[c]), 2'(m_ms1[c]), 2'(m_ms0[c]),
                 2'(m_ce[c]), 2'(m_ck[c]), 2'(m_oe[c]),
                 2'(m_dsel[c][3]), 2'(m_dsel[c][2]), 2'(m_dsel[c][1]), 2'(m_dsel[c][0])};
            v[c*CW +: CW] = w;
        end
        return v;
    endfunction

    task automatic shift_all(input logic [TOTB-1:0] v);
        for (int i = 0; i < TOTB; i++) begin
            @(posedge clk); #1;
            cfg_shift = 1'b1; cfg_sin = v[i];
        end
        @(posedge clk); #1;
        cfg_shift = 1'b0; cfg_sin = 1'b0;
    endtask

    task automatic commit();
        @(posedge clk); #1;
        cfg_update = 1'b1;
        @(posedge clk); #1;
        cfg_update = 1'b0;
        model_loaded = 1;
    endtask

    // driver: apply stimulus and queue the expected routing
    task automatic apply(input logic [15:0] p, input logic [3:0] g, input string req);
        exp_t e;
        @(posedge clk); #1;
        pin_in = p; gclk_in = g;
        e.data = '0; e.oe = '0; e.ck = '0; e.ce = '0; e.ms = '0; e.req = req;
        if (model_loaded) begin
            for (int c = 0; c < NC; c++) begin
                for (int d = 0; d < 4; d++) e.data[c*4+d] = p[d*4 + m_dsel[c][d]];
                e.oe[c]     = p[m_oe[c]];
                e.ck[c]     = m_glb[c] ? g[m_gidx[c]] : p[4 + m_ck[c]];
                e.ce[c]     = p[4 + m_ce[c]];
                e.ms[c*2]   = p[8 + m_ms0[c]];
                e.ms[c*2+1] = p[12 + m_ms1[c]];
            end
        end
        sb.push_back(e);
    endtask

    task automatic chk1(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // monitor: compare outputs away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (cell_data !== e.data || cell_oe !== e.oe || cell_clk !== e.ck ||
                cell_clken !== e.ce || cell_msel !== e.ms) begin
                errors++;
                $display("FAIL %s: actual d=%h oe=%b ck=%b ce=%b ms=%b expected d=%h oe=%b ck=%b ce=%b ms=%b",
                         e.req, cell_data, cell_oe, cell_clk, cell_clken, cell_msel,
                         e.data, e.oe, e.ck, e.ce, e.ms);
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [TOTB-1:0] v1, v2;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk1(cfg_sout, 1'b0, "R10 sout after reset");
        apply(16'hFFFF, 4'hF, "R3 dark after reset");
        apply(16'hA5C3, 4'h5, "R3 dark after reset");

        // configuration 1: distinct per-cell pin choices
        for (int c = 0; c < NC; c++) begin
            for (int d = 0; d < 4; d++) m_dsel[c][d] = (c + d) % 4;
            m_oe[c] = c; m_ck[c] = (c + 1) % 4; m_ce[c] = (c + 2) % 4;
            m_ms0[c] = 3 - c; m_ms1[c] = c ^ 1; m_glb[c] = 0; m_gidx[c] = 0;
        end
        v1 = build_vec();
        shift_all(v1);
        #1;
        chk1(cfg_sout, v1[0], "R1 first bit reaches sout");
        apply(16'hFFFF, 4'hF, "R2 staged but not committed");
        repeat (3) @(posedge clk);
        #1;
        chk1(cfg_sout, v1[0], "R1 hold while shift low");
        commit();
        for (int i = 0; i < 16; i++) apply(16'(1) << i, 4'h0, "R4 R5 R6 R8 walking one");
        apply(16'hFFFF, 4'h0, "R4 R5 R6 R8 all ones");
        apply(16'hA5C3, 4'hF, "R4 R6 mixed pattern");
        apply(16'h3C96, 4'h0, "R5 R8 mixed pattern");

        // configuration 2: shared pins and global clocks
        for (int c = 0; c < NC; c++) begin
            for (int d = 0; d < 4; d++) m_dsel[c][d] = 2;
            m_oe[c] = 1; m_ck[c] = 0; m_ce[c] = 3; m_ms0[c] = 2; m_ms1[c] = 2;
            m_glb[c] = 1; m_gidx[c] = c;
        end
        v2 = build_vec();
        // shifting alone must not disturb configuration 1 routing
        model_loaded = 1;
        for (int c = 0; c < NC; c++) staged[c] = 1'b0;
        begin
            int sd[NC][4]; int so[NC], sk[NC], se[NC], s0[NC], s1[NC], sg[NC], si[NC];
            sd = m_dsel; so = m_oe; sk = m_ck; se = m_ce; s0 = m_ms0; s1 = m_ms1; sg = m_glb; si = m_gidx;
            for (int c = 0; c < NC; c++) begin
                for (int d = 0; d < 4; d++) m_dsel[c][d] = (c + d) % 4;
                m_oe[c] = c; m_ck[c] = (c + 1) % 4; m_ce[c] = (c + 2) % 4;
                m_ms0[c] = 3 - c; m_ms1[c] = c ^ 1; m_glb[c] = 0; m_gidx[c] = 0;
            end
            shift_all(v2);
            apply(16'h5A5A, 4'h3, "R2 shift without update keeps routing");
            m_dsel = sd; m_oe = so; m_ck = sk; m_ce = se; m_ms0 = s0; m_ms1 = s1; m_glb = sg; m_gidx = si;
        end
        commit();
        apply(16'h0004, 4'h0, "R9 shared pin high");
        apply(16'hFFFB, 4'hF, "R9 shared pin low");
        apply(16'h4444, 4'h0, "R9 fan-out across sets");
        apply(16'h0000, 4'h5, "R7 global clocks 0101");
        apply(16'hFFFF, 4'hA, "R7 global clocks 1010");
        apply(16'h0F0F, 4'h9, "R6 R7 clock enable from set B");

        // one more shift moves the next bit to sout
        @(posedge clk); #1;
        cfg_shift = 1'b1; cfg_sin = 1'b0;
        @(posedge clk); #1;
        cfg_shift = 1'b0;
        chk1(cfg_sout, v2[1], "R1 single step");

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule